// File: doc/BRIEF.md
# DMA Atomic Transfer Engine

This block carries out one indivisible read-then-write move between a source address and a destination address each time it is started. When started, it takes a snapshot of the control fields: the data size (byte, halfword or word), unit or four-beat burst, and an increment/fixed choice for each side. It then issues one or four reads on a memory read port and stores the returned data in a small beat buffer. After the last read has been accepted, it issues the same number of writes on a memory write port. It signals completion with a one-cycle done strobe. A surrounding channel controller starts it once per atomic operation and counts operations.

The engine keeps the source and destination addresses itself. After a load, each address steps by the data size per beat on the side set to increment, or holds on the side set to fixed. The addresses carry over from one operation to the next, so a chain of starts walks through memory without reloading. A reserved size code makes no bus access and finishes with an error flag.

Top module: `dma_atomic_xfer`

## Requirements
- R1: Within one operation, every read is accepted before the first write is presented; rd_valid_o and wr_valid_o are never high together.
- R2: Write beat k carries exactly the data returned by read beat k of the same operation.
- R3: burst_i = 0 gives one read and one write per operation; burst_i = 1 gives four of each.
- R4: size_i 00 = byte, 01 = halfword, 10 = word is driven on rd_size_o and wr_size_o for every beat. An incrementing address advances by 1, 2 or 4 after each accepted beat on its own side.
- R5: src_fixed_i = 1 (resp. dst_fixed_i = 1) holds that side's address for every beat. The two sides are chosen independently; 0 means increment.
- R6: Reset clears both addresses to 0. load_i while idle sets them to src_init_i and dst_init_i. Otherwise they persist across operations, so the next operation starts where the previous one ended (visible on src_addr_o and dst_addr_o).
- R7: done_o is high for exactly one cycle, the cycle after the final write is accepted, and busy_o is low in that cycle. A start presented in that same cycle is accepted.
- R8: size_i = 11 at start makes no read or write. done_o and err_o are both high in the next cycle, and the addresses are unchanged.
- R9: start_i and load_i are ignored while busy_o is high. The control fields are sampled only in the cycle a start is accepted.
- R10: A presented read or write holds its valid, address (and write data) steady until ready is seen.
- R11: When load_i and start_i are high in the same idle cycle, the load takes effect and the start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin one atomic operation (idle only) |
| load_i | input | 1 | Load both addresses (idle only) |
| size_i | input | 2 | Data size code: 00 byte, 01 halfword, 10 word, 11 reserved |
| burst_i | input | 1 | 0 = one beat, 1 = four beats |
| src_fixed_i | input | 1 | 1 = source address does not step |
| dst_fixed_i | input | 1 | 1 = destination address does not step |
| src_init_i | input | AW | Source address for load |
| dst_init_i | input | AW | Destination address for load |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Read accepted; rd_data_i valid this cycle |
| rd_addr_o | output | AW | Read address |
| rd_size_o | output | 2 | Read size code |
| rd_data_i | input | DW | Read data |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write accepted |
| wr_addr_o | output | AW | Write address |
| wr_size_o | output | 2 | Write size code |
| wr_data_o | output | DW | Write data |
| src_addr_o | output | AW | Current source address |
| dst_addr_o | output | AW | Current destination address |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Reserved size seen; high with done_o |

## Verification
The done strobe of one operation and the acceptance of the next start can fall in the same cycle. The bench provokes this by raising start_i with new control fields in the very cycle it sees done_o high. It judges the result by busy_o rising on the next cycle, by done_o having lasted only one cycle, and by the second operation's reads starting at the address where the first one ended. A second collision, load and start in one idle cycle, is judged by the loaded addresses appearing while busy_o stays low.

// File: rtl/dma_xfer_pkg.sv
// Shared types and helpers for the atomic transfer engine.
// Assumes size codes 00/01/10 are valid and 11 is reserved.
package dma_xfer_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_WRITE = 2'b10
    } state_e;

    // Bytes per beat for a size code (reserved code yields 0).
    function automatic logic [2:0] size_step(input logic [1:0] sz);
        return (sz == SZ_RSVD) ? 3'd0 : (3'd1 << sz);
    endfunction

endpackage

// File: rtl/dma_addr_gen.sv
// Address register for one side of the transfer.
// Loads on load_i, otherwise steps by the size after each accepted beat
// unless the side is fixed. Assumes load and step never coincide.
module dma_addr_gen #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] init_i,
    input  logic          step_i,
    input  logic          fixed_i,
    input  logic [1:0]    size_i,
    output logic [AW-1:0] addr_o
);
    import dma_xfer_pkg::*;

    logic [AW-1:0] addr_q;

    // Hold, load or advance the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= init_i;
        end else if (step_i && !fixed_i) begin
            addr_q <= addr_q + AW'(size_step(size_i));
        end
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/dma_beat_buf.sv
// Small beat store between the read and write phases.
// One entry per burst beat, written by index, read combinationally by index.
module dma_beat_buf #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    parameter int IW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [IW-1:0] wr_idx_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [IW-1:0] rd_idx_i,
    output logic [DW-1:0] rd_data_o
);
    logic [DEPTH-1:0][DW-1:0] ent;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [DW-1:0] q;
        // Capture read data into this entry when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en_i && (wr_idx_i == IW'(g))) begin
                q <= wr_data_i;
            end
        end
        assign ent[g] = q;
    end

    assign rd_data_o = ent[rd_idx_i];

endmodule

// File: rtl/dma_xfer_fsm.sv
// Sequencer for one atomic operation: idle, read phase, write phase.
// Snapshots the control fields at start; ignores start/load while busy.
// Assumes the read port returns data in the cycle it asserts ready.
module dma_xfer_fsm #(
    parameter int BEATS = 4,
    parameter int BW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          load_i,
    input  logic [1:0]    size_i,
    input  logic          burst_i,
    input  logic          sfix_i,
    input  logic          dfix_i,
    input  logic          rd_ready_i,
    input  logic          wr_ready_i,
    output logic          rd_valid_o,
    output logic          wr_valid_o,
    output logic          rd_step_o,
    output logic          wr_step_o,
    output logic          load_ok_o,
    output logic [BW-1:0] beat_o,
    output logic [1:0]    size_q_o,
    output logic          sfix_q_o,
    output logic          dfix_q_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o
);
    import dma_xfer_pkg::*;

    state_e        state_q;
    logic [BW-1:0] beat_q;
    logic [1:0]    size_q;
    logic          burst_q, sfix_q, dfix_q;
    logic          done_q, err_q;
    logic          accept, last_beat;

    // Start is taken only when idle and no load competes.
    assign accept    = (state_q == ST_IDLE) && start_i && !load_i;
    assign last_beat = burst_q ? (beat_q == BW'(BEATS - 1)) : (beat_q == '0);

    // Phase sequencing, beat counting and completion strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            size_q  <= SZ_BYTE;
            burst_q <= 1'b0;
            sfix_q  <= 1'b0;
            dfix_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        size_q  <= size_i;
                        burst_q <= burst_i;
                        sfix_q  <= sfix_i;
                        dfix_q  <= dfix_i;
                        beat_q  <= '0;
                        if (size_i == SZ_RSVD) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end else begin
                            state_q <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (rd_ready_i) begin
                        if (last_beat) begin
                            beat_q  <= '0;
                            state_q <= ST_WRITE;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end
                end
                ST_WRITE: begin
                    if (wr_ready_i) begin
                        if (last_beat) begin
                            beat_q  <= '0;
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_valid_o = (state_q == ST_READ);
    assign wr_valid_o = (state_q == ST_WRITE);
    assign rd_step_o  = rd_valid_o && rd_ready_i;
    assign wr_step_o  = wr_valid_o && wr_ready_i;
    assign load_ok_o  = (state_q == ST_IDLE) && load_i;
    assign beat_o     = beat_q;
    assign size_q_o   = size_q;
    assign sfix_q_o   = sfix_q;
    assign dfix_q_o   = dfix_q;
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = done_q;
    assign err_o      = err_q;

endmodule

// File: rtl/dma_atomic_xfer.sv
// Atomic read-then-write transfer engine.
// Connects the sequencer, the beat buffer and one address generator per side.
// Assumes BURST_BEATS >= 2 and a read port that returns data with ready.
module dma_atomic_xfer #(
    parameter int AW          = 32,
    parameter int DW          = 32,
    parameter int BURST_BEATS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          load_i,
    input  logic [1:0]    size_i,
    input  logic          burst_i,
    input  logic          src_fixed_i,
    input  logic          dst_fixed_i,
    input  logic [AW-1:0] src_init_i,
    input  logic [AW-1:0] dst_init_i,
    output logic          rd_valid_o,
    input  logic          rd_ready_i,
    output logic [AW-1:0] rd_addr_o,
    output logic [1:0]    rd_size_o,
    input  logic [DW-1:0] rd_data_i,
    output logic          wr_valid_o,
    input  logic          wr_ready_i,
    output logic [AW-1:0] wr_addr_o,
    output logic [1:0]    wr_size_o,
    output logic [DW-1:0] wr_data_o,
    output logic [AW-1:0] src_addr_o,
    output logic [AW-1:0] dst_addr_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o
);
    localparam int BW = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;

    logic          rd_step, wr_step, load_ok;
    logic [BW-1:0] beat;
    logic [1:0]    size_q;
    logic          sfix_q, dfix_q;
    logic [AW-1:0] src_addr, dst_addr;

    dma_xfer_fsm #(.BEATS(BURST_BEATS), .BW(BW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .load_i     (load_i),
        .size_i     (size_i),
        .burst_i    (burst_i),
        .sfix_i     (src_fixed_i),
        .dfix_i     (dst_fixed_i),
        .rd_ready_i (rd_ready_i),
        .wr_ready_i (wr_ready_i),
        .rd_valid_o (rd_valid_o),
        .wr_valid_o (wr_valid_o),
        .rd_step_o  (rd_step),
        .wr_step_o  (wr_step),
        .load_ok_o  (load_ok),
        .beat_o     (beat),
        .size_q_o   (size_q),
        .sfix_q_o   (sfix_q),
        .dfix_q_o   (dfix_q),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

    dma_beat_buf #(.DW(DW), .DEPTH(BURST_BEATS), .IW(BW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (rd_step),
        .wr_idx_i  (beat),
        .wr_data_i (rd_data_i),
        .rd_idx_i  (beat),
        .rd_data_o (wr_data_o)
    );

    dma_addr_gen #(.AW(AW)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_ok),
        .init_i  (src_init_i),
        .step_i  (rd_step),
        .fixed_i (sfix_q),
        .size_i  (size_q),
        .addr_o  (src_addr)
    );

    dma_addr_gen #(.AW(AW)) u_dst (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_ok),
        .init_i  (dst_init_i),
        .step_i  (wr_step),
        .fixed_i (dfix_q),
        .size_i  (size_q),
        .addr_o  (dst_addr)
    );

    assign rd_addr_o  = src_addr;
    assign wr_addr_o  = dst_addr;
    assign rd_size_o  = size_q;
    assign wr_size_o  = size_q;
    assign src_addr_o = src_addr;
    assign dst_addr_o = dst_addr;

endmodule

// File: rtl/dma_atomic_xfer_chk.sv
// Property checker for the atomic transfer engine, bound to the top.
// Observes the ports plus the snapshotted control fields.
module dma_atomic_xfer_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_valid_o,
    input logic          rd_ready_i,
    input logic [AW-1:0] rd_addr_o,
    input logic [1:0]    rd_size_o,
    input logic          wr_valid_o,
    input logic          wr_ready_i,
    input logic [AW-1:0] wr_addr_o,
    input logic [DW-1:0] wr_data_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          err_o,
    input logic [1:0]    size_q,
    input logic          sfix_q,
    input logic          dfix_q
);
    import dma_xfer_pkg::*;

    assert_phase_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid_o && wr_valid_o));

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));

    assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

    assert_src_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && rd_ready_i && !sfix_q |=>
            !rd_valid_o || (rd_addr_o == $past(rd_addr_o) + AW'(size_step(size_q))));

    assert_dst_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && wr_ready_i && !dfix_q |=>
            !wr_valid_o || (wr_addr_o == $past(wr_addr_o) + AW'(size_step(size_q))));

    assert_src_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o && rd_ready_i && sfix_q |=> !rd_valid_o || $stable(rd_addr_o));

    assert_dst_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && wr_ready_i && dfix_q |=> !wr_valid_o || $stable(wr_addr_o));

    assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !err_o |-> $past(wr_valid_o && wr_ready_i));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    assert_no_rsvd_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o || wr_valid_o |-> rd_size_o != SZ_RSVD);

endmodule

bind dma_atomic_xfer dma_atomic_xfer_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_valid_o (rd_valid_o),
    .rd_ready_i (rd_ready_i),
    .rd_addr_o  (rd_addr_o),
    .rd_size_o  (rd_size_o),
    .wr_valid_o (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .size_q     (size_q),
    .sfix_q     (sfix_q),
    .dfix_q     (dfix_q)
);

// File: tb/dma_atomic_xfer_bench.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table walked by one loop, then directed cases.
module dma_atomic_xfer_bench;

    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, load_i = 1'b0;
    logic [1:0]    size_i = 2'b00;
    logic          burst_i = 1'b0, src_fixed_i = 1'b0, dst_fixed_i = 1'b0;
    logic [AW-1:0] src_init_i = '0, dst_init_i = '0;
    logic          rd_valid_o, rd_ready_i = 1'b0;
    logic [AW-1:0] rd_addr_o;
    logic [1:0]    rd_size_o;
    logic [DW-1:0] rd_data_i = '0;
    logic          wr_valid_o, wr_ready_i = 1'b0;
    logic [AW-1:0] wr_addr_o;
    logic [1:0]    wr_size_o;
    logic [DW-1:0] wr_data_o;
    logic [AW-1:0] src_addr_o, dst_addr_o;
    logic          busy_o, done_o, err_o;

    dma_atomic_xfer #(.AW(AW), .DW(DW), .BURST_BEATS(4)) u_dma_atomic_xfer (.*);

    always #4 clk = ~clk;   // 125 MHz

    int errs = 0, checks = 0;
    int cyc = 0, rd_n = 0, wr_n = 0, done_cnt = 0;
    bit stall_sel = 1'b0, wr_hs_prev = 1'b0;
    logic [AW-1:0] rd_a [16];
    logic [1:0]    rd_s [16];
    logic [AW-1:0] wr_a [16];
    logic [DW-1:0] wr_d [16];
    logic [1:0]    wr_s [16];

    function automatic logic [DW-1:0] rdv(input logic [AW-1:0] a);
        return (a ^ 32'h5A5A_0000) ^ {a[7:0], 24'h0} ^ 32'h0000_00C3;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory responder and handshake logger, acting between clock edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o && !err_o)
                chk(wr_hs_prev, "R7", "done follows final write acceptance", 32'(wr_hs_prev), 1);
            if (done_o) done_cnt++;
        end
        cyc++;
        rd_ready_i = stall_sel ? cyc[0] : 1'b1;
        wr_ready_i = stall_sel ? cyc[1] : 1'b1;
        rd_data_i  = rdv(rd_addr_o);
        wr_hs_prev = wr_valid_o && wr_ready_i;
        if (rd_valid_o && rd_ready_i) begin
            rd_a[rd_n % 16] = rd_addr_o;
            rd_s[rd_n % 16] = rd_size_o;
            rd_n++;
        end
        if (wr_valid_o && wr_ready_i) begin
            wr_a[wr_n % 16] = wr_addr_o;
            wr_d[wr_n % 16] = wr_data_o;
            wr_s[wr_n % 16] = wr_size_o;
            wr_n++;
        end
    end

    // Run one operation and check beats, order, data, sizes and end addresses.
    task automatic run_op(input logic [1:0] sz, input bit bu, input bit sf, input bit df,
                          input bit st, input bit do_load, input bit disturb,
                          input logic [AW-1:0] src, input logic [AW-1:0] dst,
                          input int beats, input logic [AW-1:0] src_end,
                          input logic [AW-1:0] dst_end);
        int n = 0;
        int d0;
        bit ok_addr = 1'b1, ok_data = 1'b1, ok_size = 1'b1;
        @(negedge clk);
        stall_sel = st;
        if (do_load) begin
            load_i = 1'b1; src_init_i = src; dst_init_i = dst;
            @(negedge clk);
            load_i = 1'b0;
        end
        rd_n = 0; wr_n = 0; d0 = done_cnt;
        size_i = sz; burst_i = bu; src_fixed_i = sf; dst_fixed_i = df; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R9: fields change after start; the running operation must not follow them.
        size_i = 2'b11; burst_i = ~bu; src_fixed_i = ~sf; dst_fixed_i = ~df;
        if (disturb) begin
            @(negedge clk);
            load_i = 1'b1; start_i = 1'b1; src_init_i = 32'hFFFF_0000; dst_init_i = 32'hEEEE_0000;
            @(negedge clk);
            load_i = 1'b0; start_i = 1'b0;
        end
        while (!done_o && n < 500) begin @(negedge clk); n++; end
        chk(done_o, "R7", "done seen before timeout", 32'(done_o), 1);
        chk(!busy_o, "R7", "idle in done cycle", 32'(busy_o), 0);
        chk(!err_o, "R8", "no error for valid size", 32'(err_o), 0);
        chk(rd_n == beats, "R3", "read beat count", rd_n, beats);
        chk(wr_n == beats, "R3", "write beat count", wr_n, beats);
        for (int i = 0; i < beats && i < 16; i++) begin
            logic [AW-1:0] ea = src + (sf ? 0 : i * (1 << sz));
            logic [AW-1:0] eb = dst + (df ? 0 : i * (1 << sz));
            if (rd_a[i] != ea || wr_a[i] != eb) ok_addr = 1'b0;
            if (wr_d[i] != rdv(ea)) ok_data = 1'b0;
            if (rd_s[i] != sz || wr_s[i] != sz) ok_size = 1'b0;
        end
        chk(ok_addr, "R5", "per-beat read/write addresses (R4 step)", rd_a[beats-1], src_end);
        chk(ok_data, "R2", "write data equals read data per beat", wr_d[0], rdv(src));
        chk(ok_size, "R4", "size code on both ports", rd_s[0], sz);
        chk(src_addr_o == src_end, "R6", "source end address", src_addr_o, src_end);
        chk(dst_addr_o == dst_end, "R6", "destination end address", dst_addr_o, dst_end);
        @(negedge clk);
        chk(done_cnt - d0 == 1, "R7", "single done pulse", done_cnt - d0, 1);
    endtask

    typedef struct packed {
        logic [1:0]  sz;
        logic        bu, sf, df, st;
        logic [31:0] src, dst;
        logic [3:0]  beats;
        logic [31:0] src_end, dst_end;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1000, 32'h2000, 4'd4, 32'h1010, 32'h2010},
        '{2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 32'h1001, 32'h3000, 4'd4, 32'h1005, 32'h3000},
        '{2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 32'h4002, 32'h5000, 4'd1, 32'h4002, 32'h5002},
        '{2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 32'h6000, 32'h7000, 4'd4, 32'h6008, 32'h7008},
        '{2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 32'h8000, 32'h9000, 4'd1, 32'h8000, 32'h9000}
    };

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        errs++; checks++;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        chk(src_addr_o == 0 && dst_addr_o == 0, "R6", "addresses after reset", src_addr_o, 0);
        chk(!busy_o && !done_o && !err_o && !rd_valid_o && !wr_valid_o, "R1",
            "quiet after reset", {busy_o, done_o, err_o, rd_valid_o, wr_valid_o}, 0);

        // Vector table: R2 R3 R4 R5 R6 R9 R10 under mixed sizes, modes and stalls.
        foreach (VECS[k]) begin
            run_op(VECS[k].sz, VECS[k].bu, VECS[k].sf, VECS[k].df, VECS[k].st, 1'b1, 1'b0,
                   VECS[k].src, VECS[k].dst, int'(VECS[k].beats), VECS[k].src_end, VECS[k].dst_end);
        end

        // R6: persistence, second operation continues without reload.
        run_op(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h1000, 32'h2000, 4, 32'h1010, 32'h2010);
        run_op(2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1010, 32'h2010, 4, 32'h1020, 32'h2020);

        // R9: start/load while busy ignored (stalled burst).
        run_op(2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'hA000, 32'hB000, 4, 32'hA008, 32'hB008);

        // R7: start in the done cycle is accepted (chained word single).
        stall_sel = 1'b0;
        size_i = 2'b10; burst_i = 1'b0; src_fixed_i = 1'b0; dst_fixed_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b0 || rd_valid_o, "R7", "setup start", 32'(busy_o), 1);
        while (busy_o) @(negedge clk);
        chk(done_o, "R7", "first chained done", 32'(done_o), 1);
        start_i = 1'b1; size_i = 2'b00; burst_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && !done_o, "R7", "start in done cycle accepted, done one cycle",
            {busy_o, done_o}, 2'b10);
        while (busy_o) @(negedge clk);
        chk(src_addr_o == 32'hA00D, "R7", "chained op continued addresses", src_addr_o, 32'hA00D);
        @(negedge clk);

        // R8: reserved size makes no access, flags error with done.
        rd_n = 0; wr_n = 0;
        size_i = 2'b11; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; size_i = 2'b00;
        chk(done_o && err_o, "R8", "done and error after reserved start", {done_o, err_o}, 2'b11);
        chk(!busy_o, "R8", "stays idle", 32'(busy_o), 0);
        @(negedge clk);
        chk(!done_o && !err_o, "R8", "error pulse one cycle", {done_o, err_o}, 0);
        chk(rd_n == 0 && wr_n == 0, "R8", "no bus access", rd_n + wr_n, 0);
        chk(src_addr_o == 32'hA00D, "R8", "address unchanged", src_addr_o, 32'hA00D);

        // R11: load and start together: load applied, start ignored.
        d0 = done_cnt;
        load_i = 1'b1; start_i = 1'b1; size_i = 2'b10; src_init_i = 32'hC000; dst_init_i = 32'hD000;
        @(negedge clk);
        load_i = 1'b0; start_i = 1'b0;
        chk(!busy_o, "R11", "start ignored with load", 32'(busy_o), 0);
        chk(src_addr_o == 32'hC000 && dst_addr_o == 32'hD000, "R11", "load applied",
            src_addr_o, 32'hC000);
        repeat (3) @(negedge clk);
        chk(done_cnt == d0 && rd_n == 0, "R11", "no operation ran", rd_n, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule